// File: doc/BRIEF.md
# Banked Program Counter with Fixed Vectors

This block generates the fetch address for a small 8-bit controller whose 4096-word program space is split into a lower and an upper half of 2048 words each. The most significant address bit selects the half. Each cycle the block accepts one of several commands: hold, advance to the next word, jump, call, or take an interrupt. It registers the resulting address and presents it as the address of the next fetch.

Switching halves is a two-step process. A bank-select command only records the wanted half in a pending flag. The top address bit takes that value at the next jump or call, so straight-line code never crosses into the other half. Interrupts send the program to fixed low addresses: the external request goes to 3 and the timer overflow goes to 7. Reset goes to 0. On a call or an interrupt entry, the block shows for one cycle the full address of the next sequential word, so a stack outside the block can store it.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is held and after it is released, fetch_addr is 0 and ret_valid is 0. Reset also sets the pending bank flag to 0, the lower half.
- R2: When ext_irq is high, the next fetch_addr is 3 and its bit 11 is 0.
- R3: When tmr_ovf and tmr_ie are both high and ext_irq is low, the next fetch_addr is 7.
- R4: When tmr_ovf is high and tmr_ie is low, the overflow is ignored. The next fetch_addr is the one the other inputs select, and with no other command the address is unchanged.
- R5: Commands in the same cycle are resolved in a fixed order: ext_irq, then enabled timer, then call, then jump, then step.
- R6: A step adds 1 to bits 10:0 modulo 2048 and leaves bit 11 unchanged, so 2047 steps to 0 and 4095 steps to 2048.
- R7: A jump or a call loads fetch_addr with {pending bank flag, target}. The flag used is the value held before the current cycle, so a bank select in the same cycle affects only later jumps.
- R8: bank_sel1 sets the pending flag to 1 and bank_sel0 clears it. If both are high, bank_sel0 wins. A select alone does not change fetch_addr.
- R9: Taking an interrupt does not change the pending bank flag. A later jump still lands in the half that was selected before the interrupt.
- R10: After a call or a taken interrupt, ret_valid is high for exactly one cycle. During that cycle ret_addr equals {bit 11, bits 10:0 + 1 mod 2048} of the fetch address from before the call or interrupt.
- R11: With no command active, fetch_addr holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq | input | 1 | External interrupt taken this cycle |
| tmr_ovf | input | 1 | Timer overflow |
| tmr_ie | input | 1 | Timer interrupt enable |
| step | input | 1 | Advance to next sequential word |
| jump | input | 1 | Unconditional jump to target |
| call | input | 1 | Call to target |
| target | input | 11 | Jump/call target within a bank |
| bank_sel0 | input | 1 | Select lower bank for the next jump/call |
| bank_sel1 | input | 1 | Select upper bank for the next jump/call |
| fetch_addr | output | 12 | Current fetch address |
| ret_addr | output | 12 | Return address for a call or interrupt |
| ret_valid | output | 1 | ret_addr is valid this cycle |

## Verification
Two pairs of events can land in the same cycle. An interrupt can arrive together with a jump or call, and a bank select can arrive together with the jump that it must not yet affect. The random stimulus drives every command line on its own random draw, so both collisions occur many times. Directed sequences add the exact cases: an interrupt with a call while the upper bank is pending, a select in the same cycle as a jump, and an interrupt followed by a jump. Each cycle the result is compared with a priority model in the bench, which uses the flag value from before the cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_STEP,
        OP_JUMP,
        OP_CALL,
        OP_TMR,
        OP_EXT
    } pcs_op_e;
endpackage

// File: rtl/pcs_arbiter.sv
module pcs_arbiter
    import pcs_pkg::*;
(
    input  logic    ext_irq,
    input  logic    tmr_ovf,
    input  logic    tmr_ie,
    input  logic    call,
    input  logic    jump,
    input  logic    step,
    output pcs_op_e op
);
    always_comb begin
        if (ext_irq)                op = OP_EXT;
        else if (tmr_ovf && tmr_ie) op = OP_TMR;
        else if (call)              op = OP_CALL;
        else if (jump)              op = OP_JUMP;
        else if (step)              op = OP_STEP;
        else                        op = OP_HOLD;
    end
endmodule

// File: rtl/pcs_incr.sv
module pcs_incr #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_next
);
    localparam int LOW_W = ADDR_W - 1;
    logic [LOW_W-1:0] low_inc;

    always_comb begin
        low_inc   = addr_in[LOW_W-1:0] + LOW_W'(1);
        addr_next = {addr_in[ADDR_W-1], low_inc};
    end
endmodule

// File: rtl/pcs_bank_flag.sv
module pcs_bank_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sel0,
    input  logic sel1,
    output logic flag_q
);
    logic flag_d;

    always_comb begin
        flag_d = flag_q;
        if (sel0)      flag_d = 1'b0;
        else if (sel1) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assert_sel0_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel0 |=> !flag_q);
    assert_sel1_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel1 && !sel0) |=> flag_q);
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcs_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int EXT_VEC = 3,
    parameter int TMR_VEC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_irq,
    input  logic              tmr_ovf,
    input  logic              tmr_ie,
    input  logic              step,
    input  logic              jump,
    input  logic              call,
    input  logic [ADDR_W-2:0] target,
    input  logic              bank_sel0,
    input  logic              bank_sel1,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] ret_addr,
    output logic              ret_valid
);
    localparam int LOW_W = ADDR_W - 1;
    localparam logic [ADDR_W-1:0] EXT_ADDR = ADDR_W'(EXT_VEC);
    localparam logic [ADDR_W-1:0] TMR_ADDR = ADDR_W'(TMR_VEC);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ret;
        logic              ret_vld;
    } pcs_state_t;

    pcs_state_t        st_d, st_q;
    pcs_op_e           op;
    logic [ADDR_W-1:0] seq_addr;
    logic              bank_q;

    pcs_arbiter u_arb (
        .ext_irq (ext_irq),
        .tmr_ovf (tmr_ovf),
        .tmr_ie  (tmr_ie),
        .call    (call),
        .jump    (jump),
        .step    (step),
        .op      (op)
    );

    pcs_incr #(.ADDR_W(ADDR_W)) u_inc (
        .addr_in   (st_q.pc),
        .addr_next (seq_addr)
    );

    pcs_bank_flag u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel0   (bank_sel0),
        .sel1   (bank_sel1),
        .flag_q (bank_q)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ret_vld = 1'b0;
        unique case (op)
            OP_EXT: begin
                st_d.pc      = EXT_ADDR;
                st_d.ret     = seq_addr;
                st_d.ret_vld = 1'b1;
            end
            OP_TMR: begin
                st_d.pc      = TMR_ADDR;
                st_d.ret     = seq_addr;
                st_d.ret_vld = 1'b1;
            end
            OP_CALL: begin
                st_d.pc      = {bank_q, target};
                st_d.ret     = seq_addr;
                st_d.ret_vld = 1'b1;
            end
            OP_JUMP: st_d.pc = {bank_q, target};
            OP_STEP: st_d.pc = seq_addr;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_addr = st_q.pc;
    assign ret_addr   = st_q.ret;
    assign ret_valid  = st_q.ret_vld;

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (fetch_addr == '0 && !ret_valid) || !rst_n);
    assert_ext_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |=> fetch_addr == EXT_ADDR && !fetch_addr[ADDR_W-1]);
    assert_tmr_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_irq && tmr_ovf && tmr_ie) |=> fetch_addr == TMR_ADDR);
    assert_tmr_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ovf && !tmr_ie && !ext_irq && !call && !jump && !step) |=> $stable(fetch_addr));
    assert_step_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ext_irq && !(tmr_ovf && tmr_ie) && !call && !jump)
        |=> fetch_addr[ADDR_W-1] == $past(fetch_addr[ADDR_W-1])
            && fetch_addr[LOW_W-1:0] == $past(fetch_addr[LOW_W-1:0]) + LOW_W'(1));
    assert_jump_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (jump && !call && !ext_irq && !(tmr_ovf && tmr_ie))
        |=> fetch_addr[LOW_W-1:0] == $past(target));
    assert_ret_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> $past(call || ext_irq || (tmr_ovf && tmr_ie)));
    assert_ret_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (call || ext_irq || (tmr_ovf && tmr_ie)) |=> ret_valid);
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_irq && !tmr_ovf && !call && !jump && !step) |=> $stable(fetch_addr));
endmodule

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ext_irq, tmr_ovf, tmr_ie, step, jump, call;
    logic [10:0] target;
    logic        bank_sel0, bank_sel1;
    logic [11:0] fetch_addr, ret_addr;
    logic        ret_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [11:0] m_pc;
    logic [11:0] m_ret;
    logic        m_rv;
    logic        m_bank;

    always #5 clk = ~clk;

    pc_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .tmr_ovf(tmr_ovf),
        .tmr_ie(tmr_ie), .step(step), .jump(jump), .call(call),
        .target(target), .bank_sel0(bank_sel0), .bank_sel1(bank_sel1),
        .fetch_addr(fetch_addr), .ret_addr(ret_addr), .ret_valid(ret_valid)
    );

    function automatic logic [11:0] seq_of(logic [11:0] a);
        return {a[11], a[10:0] + 11'd1};
    endfunction

    function automatic string req_of(logic e, logic t, logic te, logic c,
                                     logic j, logic s);
        if (e)               return "R2/R5";
        else if (t && te)    return "R3/R5";
        else if (c)          return "R7/R10";
        else if (j)          return "R7";
        else if (s)          return "R6";
        else if (t)          return "R4";
        else                 return "R11";
    endfunction

    task automatic check(string req, logic [11:0] act, logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        ext_irq = 0; tmr_ovf = 0; tmr_ie = 0; step = 0; jump = 0; call = 0;
        target = '0; bank_sel0 = 0; bank_sel1 = 0;
    endtask

    task automatic cycle(logic e, logic t, logic te, logic s, logic j,
                         logic c, logic [10:0] tg, logic b0, logic b1);
        string r;
        ext_irq = e; tmr_ovf = t; tmr_ie = te; step = s; jump = j; call = c;
        target = tg; bank_sel0 = b0; bank_sel1 = b1;
        @(posedge clk);
        r = req_of(e, t, te, c, j, s);
        m_rv = 1'b0;
        if (e)            begin m_ret = seq_of(m_pc); m_rv = 1; m_pc = 12'd3; end
        else if (t && te) begin m_ret = seq_of(m_pc); m_rv = 1; m_pc = 12'd7; end
        else if (c)       begin m_ret = seq_of(m_pc); m_rv = 1; m_pc = {m_bank, tg}; end
        else if (j)       m_pc = {m_bank, tg};
        else if (s)       m_pc = seq_of(m_pc);
        if (b0)      m_bank = 1'b0;
        else if (b1) m_bank = 1'b1;
        #2;
        check(r, fetch_addr, m_pc);
        check("R10", {11'd0, ret_valid}, {11'd0, m_rv});
        if (m_rv) check("R10", ret_addr, m_ret);
    endtask

    task automatic do_reset();
        rst_n = 0;
        clear_in();
        repeat (2) @(posedge clk);
        #2;
        check("R1", fetch_addr, 12'd0);
        check("R1", {11'd0, ret_valid}, 12'd0);
        rst_n = 1;
        m_pc = '0; m_bank = 0; m_rv = 0; m_ret = '0;
        @(posedge clk); #2;
        check("R1", fetch_addr, 12'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R11 idle hold, R8 select alone does not move fetch
        cycle(0,0,0,0,0,0,11'h0,0,0);
        cycle(0,0,0,0,0,0,11'h0,0,1);
        // R7 jump lands in selected upper bank
        cycle(0,0,0,0,1,0,11'h7FF,0,0);
        // R6 step wraps 4095 -> 2048
        cycle(0,0,0,1,0,0,11'h0,0,0);
        check("R6", fetch_addr, 12'h800);
        // R7 select in same cycle as jump uses old flag (1)
        cycle(0,0,0,0,1,0,11'h123,1,0);
        check("R7", fetch_addr, 12'h923);
        // now flag 0; R8 both selects -> bank 0 wins
        cycle(0,0,0,0,0,0,11'h0,1,1);
        cycle(0,0,0,0,1,0,11'h7FF,0,0);
        check("R8", fetch_addr, 12'h7FF);
        // R6 step wraps 2047 -> 0
        cycle(0,0,0,1,0,0,11'h0,0,0);
        check("R6", fetch_addr, 12'h000);
        // R4 masked overflow
        cycle(0,1,0,0,0,0,11'h0,0,0);
        check("R4", fetch_addr, 12'h000);
        // R9: select bank1, interrupt with call, then jump stays upper
        cycle(0,0,0,0,0,0,11'h0,0,1);
        cycle(1,1,1,1,1,1,11'h055,0,0);
        check("R5", fetch_addr, 12'd3);
        cycle(0,0,0,0,0,0,11'h0,0,0);
        check("R10", {11'd0, ret_valid}, 12'd0);
        cycle(0,1,1,0,1,1,11'h055,0,0);
        check("R3", fetch_addr, 12'd7);
        check("R10", ret_addr, 12'd4);
        cycle(0,0,0,0,1,0,11'h055,0,0);
        check("R9", fetch_addr, 12'h855);
        // R5 call beats jump
        cycle(0,0,0,1,1,1,11'h011,0,0);
        check("R10", ret_addr, 12'h856);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            cycle(($urandom % 16) == 0, ($urandom % 6) == 0, $urandom % 2,
                  $urandom % 2, ($urandom % 5) == 0, ($urandom % 7) == 0,
                  11'($urandom), ($urandom % 9) == 0, ($urandom % 9) == 0);
        end
        // reset mid-run clears bank flag (R1)
        cycle(0,0,0,0,0,0,11'h0,0,1);
        do_reset();
        cycle(0,0,0,0,1,0,11'h3AA,0,0);
        check("R1", fetch_addr, 12'h3AA);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule